// File: doc/BRIEF.md
# Partitioned SIMD Integer Multiplier

This block is a pipelined integer multiplier built on a single 32x16 product array that can be split into narrower independent lanes. For each operation a mode input chooses the shape of the work: one 32-bit by 16-bit product, two separate 16x16 products, four separate 8x8 products, or a full 32x32 product. The full-width case has no array of its own. It runs as two passes over the same 32x16 hardware, one for each 16-bit half of the second operand, and the two partial results are shifted and added.

Operands arrive packed on a valid/ready input stream together with a mode and a single signedness flag that applies to every lane. Products leave packed on a valid/ready output stream. Inside, the array is four byte-wide slices. Each slice multiplies one byte of the first operand by a 16-bit value. Steering logic picks each slice's operands and sign treatment for the mode, and a merge stage adds the slice products together at the offsets the mode calls for. In the narrow modes no carry crosses a lane boundary.

Back-pressure rules: an input beat is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low while a finished product waits with `out_ready` low. It is also low for the cycle in which the second pass of a full-width multiply is issued. A product on the output holds its value and stays valid until it is taken on an edge with `out_ready` high. The whole pipeline stalls while the output is held.

Top module: `simd_part_mul`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: With `in_mode` = 0 (wide), `out_prod` holds the full 64-bit value of `in_a[31:0]` times `in_b[15:0]`. The 64-bit value is sign-extended when `in_signed` is 1 and zero-extended when it is 0.
- R3: With `in_mode` = 1 (dual), lane k (k = 0, 1) is `in_a[16k+15:16k]` times `in_b[16k+15:16k]`. Its 32-bit product sits in `out_prod[32k+31:32k]`, with no carry between lanes.
- R4: With `in_mode` = 2 (quad), lane k (k = 0..3) is `in_a[8k+7:8k]` times `in_b[8k+7:8k]`. Its 16-bit product sits in `out_prod[16k+15:16k]`, with no carry between lanes.
- R5: With `in_mode` = 3 (full), `out_prod` is the 64-bit product of `in_a` and `in_b`. It is formed in two passes: first the low half of `in_b`, always taken as unsigned, then the high half shifted left by 16.
- R6: `in_signed` sets two's-complement treatment of every lane operand. When it is 0 every operand is taken as unsigned.
- R7: With `out_ready` held high, the product of a single-pass mode appears with `out_valid` in the second cycle after the cycle in which the operation is accepted. The product of the full mode appears in the third cycle.
- R8: In the cycle after a full-mode operation is accepted, `in_ready` is 0.
- R9: `out_valid` asserts exactly once per accepted operation, and products leave in acceptance order. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_prod` hold and `in_ready` is 0.
- R10: In wide mode, `in_b[31:16]` has no effect on the product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take an input beat |
| in_mode | input | 2 | 0 wide, 1 dual, 2 quad, 3 full |
| in_signed | input | 1 | 1: all operands two's complement |
| in_a | input | 32 | Packed first operand (lane 0 in low bits) |
| in_b | input | 32 | Packed second operand (lane 0 in low bits) |
| out_valid | output | 1 | Product beat valid |
| out_ready | input | 1 | Consumer takes the product beat |
| out_prod | output | 64 | Packed products (lane 0 in low bits) |

## Verification
The bench uses the default lane width of 8. This gives 32-bit operands and 64-bit products, so the boundary values are reachable directly: the most negative byte, halfword and word, all-ones, and operands whose lane products would carry into a neighbour lane if the partitioning leaked. In full mode, a negative first operand combined with a second operand whose low half has its top bit set shows whether the low pass is really unsigned. A stalled output and a mixed stream of single-pass and two-pass operations exercise back-pressure, ordering and the one-cycle ready gap.

// File: rtl/spm_pkg.sv
package spm_pkg;
  typedef enum logic [1:0] {
    MODE_WIDE = 2'd0,
    MODE_DUAL = 2'd1,
    MODE_QUAD = 2'd2,
    MODE_FULL = 2'd3
  } spm_mode_e;

  localparam int NSLICE = 4;
endpackage

// File: rtl/spm_route.sv
module spm_route
  import spm_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  spm_mode_e                        mode,
  input  logic                             sgn,
  input  logic                             pass_hi,
  input  logic [NSLICE*LANE_W-1:0]         a,
  input  logic [NSLICE*LANE_W-1:0]         b,
  output logic [NSLICE-1:0][LANE_W-1:0]    sl_a,
  output logic [NSLICE-1:0]                sl_a_sgn,
  output logic [NSLICE-1:0][2*LANE_W-1:0]  sl_b,
  output logic [NSLICE-1:0]                sl_b_sgn
);
  localparam int HW = 2 * LANE_W;

  always_comb begin
    for (int i = 0; i < NSLICE; i++) begin
      sl_a[i] = a[i*LANE_W +: LANE_W];
      unique case (mode)
        MODE_QUAD: begin
          sl_a_sgn[i] = sgn;
          sl_b[i]     = {{LANE_W{sgn & b[i*LANE_W+LANE_W-1]}}, b[i*LANE_W +: LANE_W]};
          sl_b_sgn[i] = sgn;
        end
        MODE_DUAL: begin
          sl_a_sgn[i] = sgn & (i % 2 == 1);
          sl_b[i]     = b[(i/2)*HW +: HW];
          sl_b_sgn[i] = sgn;
        end
        MODE_FULL: begin
          sl_a_sgn[i] = sgn & (i == NSLICE - 1);
          sl_b[i]     = pass_hi ? b[HW +: HW] : b[0 +: HW];
          sl_b_sgn[i] = sgn & pass_hi;
        end
        default: begin
          sl_a_sgn[i] = sgn & (i == NSLICE - 1);
          sl_b[i]     = b[0 +: HW];
          sl_b_sgn[i] = sgn;
        end
      endcase
    end
  end
endmodule

// File: rtl/spm_slice.sv
module spm_slice #(
  parameter int LANE_W = 8,
  localparam int SP_W = 3 * LANE_W + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [LANE_W-1:0]   a,
  input  logic                a_sgn,
  input  logic [2*LANE_W-1:0] b,
  input  logic                b_sgn,
  output logic [SP_W-1:0]     prod_q
);
  logic signed [LANE_W:0]   ax;
  logic signed [2*LANE_W:0] bx;
  logic signed [SP_W-1:0]   ax_w, bx_w, prod_d;

  assign ax     = $signed({a_sgn & a[LANE_W-1], a});
  assign bx     = $signed({b_sgn & b[2*LANE_W-1], b});
  assign ax_w   = SP_W'(ax);
  assign bx_w   = SP_W'(bx);
  assign prod_d = ax_w * bx_w;

  always_ff @(posedge clk) begin
    if (!rst_n)  prod_q <= '0;
    else if (en) prod_q <= prod_d;
  end

  // R6: operands taken as unsigned can never give a negative slice product
  assert_unsigned_nonneg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    en && !a_sgn && !b_sgn |=> !prod_q[SP_W-1]);
endmodule

// File: rtl/spm_merge.sv
module spm_merge
  import spm_pkg::*;
#(
  parameter int LANE_W = 8,
  localparam int SP_W = 3 * LANE_W + 2,
  localparam int P_W  = 8 * LANE_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          chk_en,
  input  spm_mode_e                     mode,
  input  logic                          sgn,
  input  logic                          pass_hi,
  input  logic [NSLICE-1:0][SP_W-1:0]   sl,
  input  logic [P_W-1:0]                partial,
  output logic [P_W-1:0]                wide_sum,
  output logic [P_W-1:0]                result
);
  localparam int HW = 2 * LANE_W;
  localparam int WW = 4 * LANE_W;

  logic [NSLICE-1:0][P_W-1:0] ext;
  logic [WW-1:0]              dual_lane [2];

  always_comb begin
    wide_sum = '0;
    for (int i = 0; i < NSLICE; i++) begin
      ext[i]   = {{(P_W-SP_W){sl[i][SP_W-1]}}, sl[i]};
      wide_sum = wide_sum + (ext[i] << (LANE_W * i));
    end
    for (int k = 0; k < 2; k++)
      dual_lane[k] = ext[2*k][WW-1:0] + (ext[2*k+1][WW-1:0] << LANE_W);
  end

  always_comb begin
    result = wide_sum;
    unique case (mode)
      MODE_DUAL: result = {dual_lane[1], dual_lane[0]};
      MODE_QUAD: for (int i = 0; i < NSLICE; i++) result[i*HW +: HW] = sl[i][HW-1:0];
      MODE_FULL: if (pass_hi) result = partial + (wide_sum << HW);
      default:   result = wide_sum;
    endcase
  end

  // R4: in quad mode every slice product fits its 16-bit lane (sign or zero extension above)
  for (genvar g = 0; g < NSLICE; g++) begin : g_fit
    assert_quad_lane_fit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      chk_en && mode == MODE_QUAD |->
        (sgn ? ((&sl[g][SP_W-1:HW-1]) || !(|sl[g][SP_W-1:HW-1]))
             : !(|sl[g][SP_W-1:HW])));
  end
endmodule

// File: rtl/simd_part_mul.sv
module simd_part_mul
  import spm_pkg::*;
#(
  parameter int LANE_W = 8,
  localparam int A_W  = NSLICE * LANE_W,
  localparam int P_W  = 8 * LANE_W,
  localparam int SP_W = 3 * LANE_W + 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [1:0]     in_mode,
  input  logic           in_signed,
  input  logic [A_W-1:0] in_a,
  input  logic [A_W-1:0] in_b,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [P_W-1:0] out_prod
);
  spm_mode_e mode_in;
  assign mode_in = spm_mode_e'(in_mode);

  // pipeline control
  logic adv, accept, issue, pend_hi;
  logic [A_W-1:0] hold_a, hold_b;
  logic           hold_sgn;

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv && !pend_hi;
  assign accept   = in_valid && in_ready;
  assign issue    = accept || (pend_hi && adv);

  // operands of the pass being issued
  spm_mode_e      cur_mode;
  logic [A_W-1:0] cur_a, cur_b;
  logic           cur_sgn;
  assign cur_mode = pend_hi ? MODE_FULL : mode_in;
  assign cur_a    = pend_hi ? hold_a    : in_a;
  assign cur_b    = pend_hi ? hold_b    : in_b;
  assign cur_sgn  = pend_hi ? hold_sgn  : in_signed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_hi  <= 1'b0;
      hold_a   <= '0;
      hold_b   <= '0;
      hold_sgn <= 1'b0;
    end else begin
      if (accept && mode_in == MODE_FULL) pend_hi <= 1'b1;
      else if (pend_hi && adv)            pend_hi <= 1'b0;
      if (accept) begin
        hold_a   <= in_a;
        hold_b   <= in_b;
        hold_sgn <= in_signed;
      end
    end
  end

  // operand steering
  logic [NSLICE-1:0][LANE_W-1:0]   sl_a;
  logic [NSLICE-1:0]               sl_a_sgn, sl_b_sgn;
  logic [NSLICE-1:0][2*LANE_W-1:0] sl_b;

  spm_route #(.LANE_W(LANE_W)) u_route (
    .mode     (cur_mode),
    .sgn      (cur_sgn),
    .pass_hi  (pend_hi),
    .a        (cur_a),
    .b        (cur_b),
    .sl_a     (sl_a),
    .sl_a_sgn (sl_a_sgn),
    .sl_b     (sl_b),
    .sl_b_sgn (sl_b_sgn)
  );

  // stage 1: slice products
  logic [NSLICE-1:0][SP_W-1:0] sl_p;

  for (genvar g = 0; g < NSLICE; g++) begin : g_slice
    spm_slice #(.LANE_W(LANE_W)) u_slice (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (issue),
      .a      (sl_a[g]),
      .a_sgn  (sl_a_sgn[g]),
      .b      (sl_b[g]),
      .b_sgn  (sl_b_sgn[g]),
      .prod_q (sl_p[g])
    );
  end

  logic      s1_valid, s1_sgn, s1_hi, s1_last;
  spm_mode_e s1_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_sgn   <= 1'b0;
      s1_hi    <= 1'b0;
      s1_last  <= 1'b0;
      s1_mode  <= MODE_WIDE;
    end else if (adv) begin
      s1_valid <= issue;
      if (issue) begin
        s1_sgn  <= cur_sgn;
        s1_hi   <= pend_hi;
        s1_mode <= cur_mode;
        s1_last <= !(cur_mode == MODE_FULL && !pend_hi);
      end
    end
  end

  // stage 2: lane merge and output register
  logic [P_W-1:0] partial, wide_sum, merged;

  spm_merge #(.LANE_W(LANE_W)) u_merge (
    .clk      (clk),
    .rst_n    (rst_n),
    .chk_en   (s1_valid),
    .mode     (s1_mode),
    .sgn      (s1_sgn),
    .pass_hi  (s1_hi),
    .sl       (sl_p),
    .partial  (partial),
    .wide_sum (wide_sum),
    .result   (merged)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_prod  <= '0;
      partial   <= '0;
    end else if (adv) begin
      out_valid <= s1_valid && s1_last;
      if (s1_valid && s1_last)  out_prod <= merged;
      if (s1_valid && !s1_last) partial  <= wide_sum;
    end
  end

  // R9: a held product keeps its value until taken
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_prod));

  // R8: no new beat in the cycle after a full-width operation is taken
  assert_ready_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_mode == MODE_FULL |=> !in_ready);

  // R7: a finished pass reaches the output on the next advancing edge
  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    adv && s1_valid && s1_last |=> out_valid);

  // R5: a first pass of a full multiply is always followed by its second pass
  assert_second_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    adv && s1_valid && !s1_last |=> s1_valid && s1_hi);
endmodule

// File: tb/simd_part_mul_tb.sv
module simd_part_mul_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, in_signed, out_valid, out_ready;
  logic [1:0]  in_mode;
  logic [31:0] in_a, in_b;
  logic [63:0] out_prod;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  simd_part_mul u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_signed(in_signed), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_prod(out_prod)
  );

  // vector: {mode[66:65], signed[64], a[63:32], b[31:0]}
  localparam int NV = 12;
  localparam logic [66:0] VEC [NV] = '{
    {2'd0, 1'b0, 32'hFFFF_FFFF, 32'h1234_FFFF},
    {2'd0, 1'b1, 32'h8000_0000, 32'h0000_8000},
    {2'd0, 1'b1, 32'h7FFF_FFFF, 32'hABCD_0003},
    {2'd1, 1'b0, 32'hFFFF_0002, 32'hFFFF_8000},
    {2'd1, 1'b1, 32'h8000_FFFF, 32'h8000_0001},
    {2'd2, 1'b0, 32'hFF80_017F, 32'hFF7F_02FF},
    {2'd2, 1'b1, 32'h80FF_7F01, 32'h80FF_81FF},
    {2'd3, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {2'd3, 1'b1, 32'h8000_0000, 32'h8000_0000},
    {2'd3, 1'b1, 32'hFFFF_FFFF, 32'h0000_8000},
    {2'd3, 1'b1, 32'h1234_5678, 32'h9ABC_DEF0},
    {2'd2, 1'b1, 32'h0000_0000, 32'h7F7F_7F7F}
  };
  localparam int NS = 6;
  localparam int SEL [NS] = '{5, 6, 3, 7, 0, 10};

  function automatic logic [63:0] model(logic [1:0] m, logic s, logic [31:0] a, logic [31:0] b);
    logic [63:0] r, x, y;
    logic [31:0] lx, ly;
    logic [15:0] qx, qy;
    r = '0;
    case (m)
      2'd0: begin
        x = s ? {{32{a[31]}}, a} : {32'b0, a};
        y = s ? {{48{b[15]}}, b[15:0]} : {48'b0, b[15:0]};
        r = x * y;
      end
      2'd1: for (int k = 0; k < 2; k++) begin
        lx = s ? {{16{a[16*k+15]}}, a[16*k +: 16]} : {16'b0, a[16*k +: 16]};
        ly = s ? {{16{b[16*k+15]}}, b[16*k +: 16]} : {16'b0, b[16*k +: 16]};
        r[32*k +: 32] = lx * ly;
      end
      2'd2: for (int k = 0; k < 4; k++) begin
        qx = s ? {{8{a[8*k+7]}}, a[8*k +: 8]} : {8'b0, a[8*k +: 8]};
        qy = s ? {{8{b[8*k+7]}}, b[8*k +: 8]} : {8'b0, b[8*k +: 8]};
        r[16*k +: 16] = qx * qy;
      end
      default: begin
        x = s ? {{32{a[31]}}, a} : {32'b0, a};
        y = s ? {{32{b[31]}}, b} : {32'b0, b};
        r = x * y;
      end
    endcase
    return r;
  endfunction

  function automatic string tag_of(logic [1:0] m);
    case (m)
      2'd0: return "R2/R10";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic present(logic [66:0] v);
    in_mode   = v[66:65];
    in_signed = v[64];
    in_a      = v[63:32];
    in_b      = v[31:0];
  endtask

  // one isolated operation with latency and single-beat checks
  task automatic run_one(logic [66:0] v);
    int lat;
    @(negedge clk);
    present(v);
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 1;
    if (v[66:65] == 2'd3) chk("R8 ready gap", {63'b0, in_ready}, 64'd0);
    while (!out_valid && lat < 8) begin
      @(negedge clk);
      lat++;
    end
    chk("R7 latency", 64'(lat), (v[66:65] == 2'd3) ? 64'd3 : 64'd2);
    chk({tag_of(v[66:65]), v[64] ? " R6 signed" : " R6 unsigned"}, out_prod,
        model(v[66:65], v[64], v[63:32], v[31:0]));
    @(negedge clk);
    chk("R9 single beat", {63'b0, out_valid}, 64'd0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] q [$];
    logic [63:0] held;
    int idx, got;
    logic accp;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    in_mode = 2'd0; in_signed = 1'b0; in_a = '0; in_b = '0;
    repeat (3) @(negedge clk);
    chk("R1 out_valid", {63'b0, out_valid}, 64'd0);
    chk("R1 in_ready", {63'b0, in_ready}, 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid after release", {63'b0, out_valid}, 64'd0);

    // table walk
    for (int i = 0; i < NV; i++) run_one(VEC[i]);

    // R10: upper half of b changes, wide product stays the same
    run_one({2'd0, 1'b1, 32'h7FFF_FFFF, 32'h0000_0003});

    // R9: back-pressure on the output
    out_ready = 1'b0;
    @(negedge clk);
    present(VEC[4]);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 valid under stall", {63'b0, out_valid}, 64'd1);
    held = out_prod;
    chk("R3 value under stall", held, model(VEC[4][66:65], VEC[4][64], VEC[4][63:32], VEC[4][31:0]));
    repeat (3) begin
      @(negedge clk);
      chk("R9 held valid", {63'b0, out_valid}, 64'd1);
      chk("R9 held product", out_prod, held);
      chk("R9 ready low on stall", {63'b0, in_ready}, 64'd0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    chk("R9 released once", {63'b0, out_valid}, 64'd0);

    // mixed stream: order, one beat per operation, ready gap after full ops
    idx = 0; got = 0; accp = 1'b0;
    @(negedge clk);
    present(VEC[SEL[0]]);
    in_valid = 1'b1;
    for (int cyc = 0; cyc < 40; cyc++) begin
      accp = in_valid && in_ready;
      if (accp) q.push_back(model(in_mode, in_signed, in_a, in_b));
      @(negedge clk);
      if (out_valid) begin
        got++;
        if (q.size() > 0) chk("R9 stream order", out_prod, q.pop_front());
        else chk("R9 extra beat", 64'd1, 64'd0);
      end
      if (accp) begin
        if (in_mode == 2'd3) chk("R8 stream gap", {63'b0, in_ready}, 64'd0);
        idx++;
        if (idx < NS) present(VEC[SEL[idx]]);
        else in_valid = 1'b0;
      end
    end
    chk("R9 stream beat count", 64'(got), 64'(NS));

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule